// File: doc/BRIEF.md
# Three-Element Replicating Load Unit

This unit executes one structure load that broadcasts its data. It takes the decoded fields of a single operation: element size, spacing, alignment bit, destination register high bit and low nibble, base register number and index register number. It also takes the current base and index register values. It reads three consecutive elements from a byte-addressed memory port, one request at a time. It then fills three 64-bit vector registers, each with copies of one element, and may update the base register.

The unit is used beside a register file and a load port. The surrounding pipeline raises `start_i` while `busy_o` is low and holds the register values steady for that cycle. It then waits for either `done_o` or `undef_o`. Illegal field combinations are refused before any memory traffic. All register-file and base updates wait until the third element has arrived, so a stalled or long-latency memory never leaves part of an operation committed.

Top module: `rep3_load_unit`

## Requirements
- R1: A size code of 3 (`size_i` = 2'b11) or `align_i` = 1 at an accepted start pulses `undef_o` for one cycle, in the cycle after the start. The unit then issues no read, makes no register or base write, and leaves `done_o` low.
- R2: Two further cases are refused exactly as in R1. The first is `rn_i` = 15. The second is a third destination above 31, where the third destination is `{dhi_i,vd_i}` plus twice the register step.
- R3: The element width in bytes is `1 << size_i` (0: 1 byte, 1: 2 bytes, 2: 4 bytes). The three reads go to base, base + width and base + 2*width, in that order, with wrap-around modulo 2^32. Addresses need no alignment, and `rd_size_o` carries the size code.
- R4: The first destination is `{dhi_i,vd_i}` (0..31). The step is 1 when `spc_i` = 0 and 2 when `spc_i` = 1. The three register writes happen on three consecutive cycles, in the order first, second, third destination.
- R5: Read data is little-endian, with the byte at the request address in bits 7:0. Each destination receives its element (element k to destination k) repeated across all 64 bits: 8, 4 or 2 copies.
- R6: Base write-back follows `rm_i`. 15 writes nothing back. 13 writes base + 3*width. Any other value writes base + `index_i`. The write-back targets register `rn_i` and occurs in the same cycle as the third register write.
- R7: No register write starts before the third read data has arrived. `done_o` pulses for exactly one cycle, in the cycle after the third register write.
- R8: A start is accepted only while `busy_o` is low. `busy_o` rises in the cycle after an accepted legal start and stays high until `done_o` has been given. A start while busy has no effect on the running operation.
- R9: At most one read is outstanding. `rd_req_o` stays high with a stable `rd_addr_o` until `rd_ready_i` is seen.
- R10: After reset `busy_o`, `rd_req_o`, `rf_we_o`, `wb_we_o`, `undef_o` and `done_o` are all low. While idle, no read and no write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start an operation (accepted when idle) |
| size_i | input | 2 | Element size code |
| spc_i | input | 1 | Register spacing: 0 single, 1 double |
| align_i | input | 1 | Alignment bit; 1 is illegal |
| dhi_i | input | 1 | Destination register number bit 4 |
| vd_i | input | 4 | Destination register number bits 3:0 |
| rn_i | input | 4 | Base register number |
| rm_i | input | 4 | Index register code |
| base_i | input | ADDR_W | Base register value |
| index_i | input | ADDR_W | Index register value |
| busy_o | output | 1 | Operation in progress |
| rd_req_o | output | 1 | Read request valid |
| rd_addr_o | output | ADDR_W | Read byte address |
| rd_size_o | output | 2 | Read size code |
| rd_ready_i | input | 1 | Read request accepted |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | MEM_W | Read data, little-endian |
| rf_we_o | output | 1 | Vector register write enable |
| rf_waddr_o | output | 5 | Vector register number |
| rf_wdata_o | output | VEC_W | Replicated write data |
| wb_we_o | output | 1 | Base write-back enable |
| wb_addr_o | output | 4 | Base register number |
| wb_data_o | output | ADDR_W | New base value |
| undef_o | output | 1 | Operation refused (one-cycle pulse) |
| done_o | output | 1 | Operation complete (one-cycle pulse) |

## Verification
Several properties are checked on every cycle. Refusal of an illegal start leaves the unit idle with no request. A stalled read request holds its address. Base write-back only accompanies a register write and never targets register 15. The done pulse is one cycle wide and ends the busy period. Nothing is issued while idle. Other behaviour shows only in the bench's scenarios. These are the exact read addresses and their order, the destination numbering under both spacings, the replicated data per size, the write-back value for each index code, wrap-around of the address, and the immunity of a running operation to a second start.

// File: rtl/rep3_pkg.sv
package rep3_pkg;
  localparam int NELEM  = 3;
  localparam int VREG_W = 5;
  localparam int GPR_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_WAIT, ST_WR, ST_DONE
  } st_e;

  typedef struct packed {
    logic [1:0]       size;
    logic [GPR_W-1:0] rn;
    logic [GPR_W-1:0] rm;
  } op_t;
endpackage

// File: rtl/rep3_decode.sv
module rep3_decode
  import rep3_pkg::*;
(
  input  logic [1:0]                   size_i,
  input  logic                         spc_i,
  input  logic                         align_i,
  input  logic                         dhi_i,
  input  logic [3:0]                   vd_i,
  input  logic [GPR_W-1:0]             rn_i,
  output logic                         illegal_o,
  output logic [NELEM-1:0][VREG_W-1:0] dest_o
);
  localparam int DW = VREG_W + 1;  // room for overflow past 31

  logic [DW-1:0] step;
  logic [DW-1:0] num [NELEM];

  assign step = spc_i ? DW'(2) : DW'(1);

  for (genvar k = 0; k < NELEM; k++) begin : g_dest
    if (k == 0) begin : g_first
      assign num[k] = {1'b0, dhi_i, vd_i};
    end else begin : g_next
      assign num[k] = num[k-1] + step;
    end
    assign dest_o[k] = num[k][VREG_W-1:0];
  end

  assign illegal_o = (size_i == 2'b11) || align_i ||
                     (rn_i == {GPR_W{1'b1}}) || num[NELEM-1][VREG_W];
endmodule

// File: rtl/rep3_lane_rep.sv
module rep3_lane_rep #(
  parameter int VEC_W = 64,
  parameter int MEM_W = 32
) (
  input  logic [1:0]       size_i,
  input  logic [MEM_W-1:0] elem_i,
  output logic [VEC_W-1:0] rep_o
);
  localparam int NBYTE = VEC_W / 8;

  for (genvar i = 0; i < NBYTE; i++) begin : g_byte
    always_comb begin
      unique case (size_i)
        2'd0:    rep_o[8*i +: 8] = elem_i[7:0];
        2'd1:    rep_o[8*i +: 8] = elem_i[8*(i%2) +: 8];
        default: rep_o[8*i +: 8] = elem_i[8*(i%4) +: 8];
      endcase
    end
  end
endmodule

// File: rtl/rep3_load_unit.sv
module rep3_load_unit
  import rep3_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int VEC_W  = 64,
  parameter int MEM_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        size_i,
  input  logic              spc_i,
  input  logic              align_i,
  input  logic              dhi_i,
  input  logic [3:0]        vd_i,
  input  logic [GPR_W-1:0]  rn_i,
  input  logic [GPR_W-1:0]  rm_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] index_i,
  output logic              busy_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [1:0]        rd_size_o,
  input  logic              rd_ready_i,
  input  logic              rd_valid_i,
  input  logic [MEM_W-1:0]  rd_data_i,
  output logic              rf_we_o,
  output logic [VREG_W-1:0] rf_waddr_o,
  output logic [VEC_W-1:0]  rf_wdata_o,
  output logic              wb_we_o,
  output logic [GPR_W-1:0]  wb_addr_o,
  output logic [ADDR_W-1:0] wb_data_o,
  output logic              undef_o,
  output logic              done_o
);
  localparam logic [1:0]       LAST_IDX = 2'(NELEM - 1);
  localparam logic [GPR_W-1:0] RM_NONE  = {GPR_W{1'b1}};
  localparam logic [GPR_W-1:0] RM_IMM   = GPR_W'(13);

  st_e                         st_q;
  logic [1:0]                  idx_q;
  op_t                         op_q;
  logic [NELEM-1:0][VREG_W-1:0] dest_q;
  logic [MEM_W-1:0]            elem_q [NELEM];
  logic [ADDR_W-1:0]           base_q, index_q;
  logic                        undef_q;

  logic                        illegal;
  logic [NELEM-1:0][VREG_W-1:0] dest;
  logic                        idle, accept, last;

  rep3_decode u_dec (
    .size_i   (size_i),
    .spc_i    (spc_i),
    .align_i  (align_i),
    .dhi_i    (dhi_i),
    .vd_i     (vd_i),
    .rn_i     (rn_i),
    .illegal_o(illegal),
    .dest_o   (dest)
  );

  rep3_lane_rep #(.VEC_W(VEC_W), .MEM_W(MEM_W)) u_rep (
    .size_i(op_q.size),
    .elem_i(elem_q[idx_q]),
    .rep_o (rf_wdata_o)
  );

  assign idle   = (st_q == ST_IDLE);
  assign accept = idle && start_i;
  assign last   = (idx_q == LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      op_q    <= '0;
      dest_q  <= '0;
      base_q  <= '0;
      index_q <= '0;
      undef_q <= 1'b0;
      for (int k = 0; k < NELEM; k++) elem_q[k] <= '0;
    end else begin
      undef_q <= accept && illegal;
      unique case (st_q)
        ST_IDLE: if (accept && !illegal) begin
          st_q    <= ST_REQ;
          idx_q   <= '0;
          op_q    <= '{size: size_i, rn: rn_i, rm: rm_i};
          dest_q  <= dest;
          base_q  <= base_i;
          index_q <= index_i;
        end
        ST_REQ:  if (rd_ready_i) st_q <= ST_WAIT;
        ST_WAIT: if (rd_valid_i) begin
          elem_q[idx_q] <= rd_data_i;
          idx_q         <= last ? '0 : idx_q + 2'd1;
          st_q          <= last ? ST_WR : ST_REQ;
        end
        ST_WR: begin
          idx_q <= last ? '0 : idx_q + 2'd1;
          if (last) st_q <= ST_DONE;
        end
        default: st_q <= ST_IDLE;  // ST_DONE
      endcase
    end
  end

  assign busy_o     = !idle;
  assign rd_req_o   = (st_q == ST_REQ);
  assign rd_addr_o  = base_q + (ADDR_W'(idx_q) << op_q.size);
  assign rd_size_o  = op_q.size;

  assign rf_we_o    = (st_q == ST_WR);
  assign rf_waddr_o = dest_q[idx_q];

  assign wb_we_o    = rf_we_o && last && (op_q.rm != RM_NONE);
  assign wb_addr_o  = op_q.rn;
  assign wb_data_o  = base_q + ((op_q.rm == RM_IMM) ? (ADDR_W'(3) << op_q.size)
                                                    : index_q);

  assign undef_o    = undef_q;
  assign done_o     = (st_q == ST_DONE);
endmodule

// File: rtl/rep3_load_chk.sv
module rep3_load_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [1:0]        size_i,
  input logic              spc_i,
  input logic              align_i,
  input logic              dhi_i,
  input logic [3:0]        vd_i,
  input logic [3:0]        rn_i,
  input logic              busy_o,
  input logic              rd_req_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              rd_ready_i,
  input logic              rf_we_o,
  input logic              wb_we_o,
  input logic [3:0]        wb_addr_o,
  input logic              undef_o,
  input logic              done_o
);
  logic [5:0] third;
  logic       bad;
  assign third = {1'b0, dhi_i, vd_i} + (spc_i ? 6'd4 : 6'd2);
  assign bad   = (size_i == 2'd3) || align_i || (rn_i == 4'd15) || (third > 6'd31);

  // R1 R2
  illegal_refused_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && bad) |=> (undef_o && !busy_o && !rd_req_o));

  // R8
  legal_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !bad) |=> (busy_o && rd_req_o && !undef_o));

  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_ready_i) |=> (rd_req_o && $stable(rd_addr_o)));

  // R6
  wb_with_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_we_o |-> (rf_we_o && wb_addr_o != 4'd15));

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));

  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!rd_req_o && !rf_we_o && !wb_we_o && !done_o));
endmodule

bind rep3_load_unit rep3_load_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .size_i    (size_i),
  .spc_i     (spc_i),
  .align_i   (align_i),
  .dhi_i     (dhi_i),
  .vd_i      (vd_i),
  .rn_i      (rn_i),
  .busy_o    (busy_o),
  .rd_req_o  (rd_req_o),
  .rd_addr_o (rd_addr_o),
  .rd_ready_i(rd_ready_i),
  .rf_we_o   (rf_we_o),
  .wb_we_o   (wb_we_o),
  .wb_addr_o (wb_addr_o),
  .undef_o   (undef_o),
  .done_o    (done_o)
);

// File: tb/rep3_load_unit_bench.sv
module rep3_load_unit_bench;
  typedef struct packed {
    logic [1:0]  sz;
    logic        t;
    logic        d;
    logic [3:0]  vd;
    logic [3:0]  rn;
    logic [3:0]  rm;
    logic [31:0] base;
    logic [31:0] idx;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 1'b0, 4'd3,  4'd2,  4'd15, 32'h0000_1000, 32'h0},
    '{2'd1, 1'b1, 1'b1, 4'd2,  4'd4,  4'd13, 32'h0000_2001, 32'h0},
    '{2'd2, 1'b0, 1'b0, 4'd14, 4'd0,  4'd5,  32'h0000_3FFE, 32'h0000_0100},
    '{2'd2, 1'b1, 1'b1, 4'd11, 4'd7,  4'd13, 32'h0001_0003, 32'h0},
    '{2'd0, 1'b1, 1'b0, 4'd0,  4'd14, 4'd0,  32'hFFFF_FFFF, 32'h0000_0002},
    '{2'd1, 1'b0, 1'b1, 4'd13, 4'd1,  4'd15, 32'h8000_0005, 32'h0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  size = '0;
  logic        spc = 1'b0, align = 1'b0, dhi = 1'b0;
  logic [3:0]  vd = '0, rn = '0, rm = '0;
  logic [31:0] base = '0, index = '0;
  logic        busy, rd_req, rd_ready, rd_valid = 1'b0;
  logic [31:0] rd_addr, rd_data = '0;
  logic [1:0]  rd_size;
  logic        rf_we, wb_we, undef, done;
  logic [4:0]  rf_waddr;
  logic [63:0] rf_wdata;
  logic [3:0]  wb_addr;
  logic [31:0] wb_data;

  always #5 clk = ~clk;

  rep3_load_unit u_rep3_load_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .size_i(size), .spc_i(spc),
    .align_i(align), .dhi_i(dhi), .vd_i(vd), .rn_i(rn), .rm_i(rm),
    .base_i(base), .index_i(index), .busy_o(busy), .rd_req_o(rd_req),
    .rd_addr_o(rd_addr), .rd_size_o(rd_size), .rd_ready_i(rd_ready),
    .rd_valid_i(rd_valid), .rd_data_i(rd_data), .rf_we_o(rf_we),
    .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata), .wb_we_o(wb_we),
    .wb_addr_o(wb_addr), .wb_data_o(wb_data), .undef_o(undef), .done_o(done)
  );

  int nchk = 0, nfail = 0, cyc = 0;

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return a[7:0] ^ (a[15:8] + 8'h3C) ^ {a[2:0], 5'h0B} ^ a[31:24];
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {mem_byte(a + 32'd3), mem_byte(a + 32'd2), mem_byte(a + 32'd1), mem_byte(a)};
  endfunction

  function automatic logic [63:0] exp_rep(input logic [31:0] w, input logic [1:0] sz);
    logic [63:0] r;
    int period;
    period = 1 << sz;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = w[8*(i % period) +: 8];
    return r;
  endfunction

  // memory model: request stalls when stall_en, one-cycle read latency
  logic       stall_en = 1'b0;
  logic [1:0] wcnt = '0;
  assign rd_ready = !stall_en || (wcnt == 2'd3);
  always @(posedge clk) begin
    rd_valid <= rd_req && rd_ready;
    rd_data  <= mem_word(rd_addr);
    if (rd_req && !rd_ready) wcnt <= wcnt + 2'd1;
    else                     wcnt <= '0;
  end

  // monitor
  logic [31:0] rd_log [8];
  logic [1:0]  rs_log [8];
  logic [4:0]  wa_log [8];
  logic [63:0] wd_log [8];
  int nrd, nwr, nwb, ndone, nundef, last_wr_cyc, done_cyc;
  logic [3:0]  wb_a;
  logic [31:0] wb_d;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rd_req && rd_ready) begin
      if (nrd < 8) begin rd_log[nrd] = rd_addr; rs_log[nrd] = rd_size; end
      nrd = nrd + 1;
    end
    if (rf_we) begin
      if (nwr < 8) begin wa_log[nwr] = rf_waddr; wd_log[nwr] = rf_wdata; end
      nwr = nwr + 1;
      last_wr_cyc = cyc;
    end
    if (wb_we) begin nwb = nwb + 1; wb_a = wb_addr; wb_d = wb_data; end
    if (done) begin ndone = ndone + 1; done_cyc = cyc; end
    if (undef) nundef = nundef + 1;
  end

  task automatic chk(input logic ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input vec_t v, input logic a_bit, input logic stall,
                        input logic poke, input logic exp_bad);
    logic [31:0] esz, exp_wb;
    int step, d0;
    nrd = 0; nwr = 0; nwb = 0; ndone = 0; nundef = 0;
    stall_en = stall;
    @(negedge clk); #1;
    size = v.sz; spc = v.t; align = a_bit; dhi = v.d; vd = v.vd;
    rn = v.rn; rm = v.rm; base = v.base; index = v.idx; start = 1'b1;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk); #1;
      start = 1'b0;
      if (poke && k == 2) begin
        // second start while busy: different fields, must be ignored (R8)
        start = 1'b1; size = 2'd2; vd = 4'd0; rm = 4'd13; base = 32'hDEAD_0000;
      end
      if (ndone != 0 || nundef != 0) break;
    end
    start = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    if (exp_bad) begin
      chk(nundef == 1, "R1/R2 undef pulse count", 64'(nundef), 64'd1);
      chk(nrd == 0 && nwr == 0 && nwb == 0, "R1/R2 no activity",
          64'(nrd + nwr + nwb), 64'd0);
      chk(ndone == 0, "R1/R2 no done", 64'(ndone), 64'd0);
      return;
    end
    esz  = 32'd1 << v.sz;
    step = v.t ? 2 : 1;
    d0   = {v.d, v.vd};
    chk(nundef == 0, "R1 no undef on legal op", 64'(nundef), 64'd0);
    chk(nrd == 3, "R9 read count", 64'(nrd), 64'd3);
    chk(nwr == 3, "R4 write count", 64'(nwr), 64'd3);
    for (int k = 0; k < 3; k++) begin
      chk(rd_log[k] == v.base + 32'(k) * esz, "R3 read address", 64'(rd_log[k]),
          64'(v.base + 32'(k) * esz));
      chk(rs_log[k] == v.sz, "R3 read size", 64'(rs_log[k]), 64'(v.sz));
      chk(wa_log[k] == 5'(d0 + k * step), "R4 dest number", 64'(wa_log[k]),
          64'(d0 + k * step));
      chk(wd_log[k] == exp_rep(mem_word(v.base + 32'(k) * esz), v.sz),
          "R5 replicated data", wd_log[k],
          exp_rep(mem_word(v.base + 32'(k) * esz), v.sz));
    end
    if (v.rm == 4'd15) begin
      chk(nwb == 0, "R6 no write-back for code 15", 64'(nwb), 64'd0);
    end else begin
      exp_wb = (v.rm == 4'd13) ? v.base + 32'd3 * esz : v.base + v.idx;
      chk(nwb == 1, "R6 write-back count", 64'(nwb), 64'd1);
      chk(wb_d == exp_wb, "R6 write-back value", 64'(wb_d), 64'(exp_wb));
      chk(wb_a == v.rn, "R6 write-back target", 64'(wb_a), 64'(v.rn));
    end
    chk(ndone == 1, "R7 done pulse width", 64'(ndone), 64'd1);
    chk(done_cyc == last_wr_cyc + 1, "R7 done follows third write",
        64'(done_cyc), 64'(last_wr_cyc + 1));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    nrd = 0; nwr = 0; nwb = 0; ndone = 0; nundef = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk({busy, rd_req, rf_we, wb_we, undef, done} == 6'b0, "R10 outputs in reset",
        64'({busy, rd_req, rf_we, wb_we, undef, done}), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({busy, rd_req, rf_we, wb_we, undef, done} == 6'b0, "R10 idle after reset",
        64'({busy, rd_req, rf_we, wb_we, undef, done}), 64'd0);

    // vector table: R3 R4 R5 R6 R7 R9, stalls on odd entries
    for (int i = 0; i < NV; i++) run_op(VECS[i], 1'b0, i[0], 1'b0, 1'b0);

    // R1 illegal size code and alignment bit
    run_op('{2'd3, 1'b0, 1'b0, 4'd1, 4'd2, 4'd15, 32'h100, 32'h0}, 1'b0, 1'b0, 1'b0, 1'b1);
    run_op('{2'd0, 1'b0, 1'b0, 4'd1, 4'd2, 4'd13, 32'h100, 32'h0}, 1'b1, 1'b0, 1'b0, 1'b1);
    // R2 base register 15, third destination past 31 (both spacings)
    run_op('{2'd1, 1'b0, 1'b0, 4'd1, 4'd15, 4'd13, 32'h100, 32'h0}, 1'b0, 1'b0, 1'b0, 1'b1);
    run_op('{2'd0, 1'b1, 1'b1, 4'd12, 4'd2, 4'd13, 32'h100, 32'h0}, 1'b0, 1'b0, 1'b0, 1'b1);
    run_op('{2'd2, 1'b0, 1'b1, 4'd14, 4'd2, 4'd13, 32'h100, 32'h0}, 1'b0, 1'b0, 1'b0, 1'b1);

    // R8 start while busy ignored
    run_op(VECS[2], 1'b0, 1'b1, 1'b1, 1'b0);
    chk(nundef == 0, "R8 busy start raised nothing", 64'(nundef), 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule